// File: doc/BRIEF.md
# Transmit Bit-Parcel Shift Register

This block sits between a transmit word queue and whatever consumes output bits. It holds one data word and hands it out in parcels of 1 to the full word width. The parcel size comes with each shift command, and bits can be taken from either the low end or the high end of the word. A load command takes a fresh word from the queue. In automatic-refill mode, a shift command that finds the register drained takes the next queued word and parcels from it in the same clock.

A running shift count records how many bits have left the current word. A programmable threshold decides when the word counts as drained. When no refill can be made, the block holds its command-ready line low, and the requester waits until the queue can supply a word. A queue read strobe goes high for exactly one cycle for each word taken. The reader is assumed to present the head word on its data lines combinationally while it is not empty.

Top module: `txshift_unit`

## Requirements
- R1: A load command (`cmd_op`=1) with the queue not empty takes `fifo_data` into the register, raises `fifo_rd` in that same cycle, and clears the shift count to 0.
- R2: In right mode (`cfg_left`=0), a shift command of n bits (`cmd_cnt`=0 means the full width) returns the low n bits of the register right-justified on `out_data`; all higher output bits are 0.
- R3: In left mode (`cfg_left`=1), a shift of n bits returns the top n bits of the register right-justified on `out_data`; all higher output bits are 0.
- R4: Bit positions vacated by a shift fill with zeros, so further shifts of a drained word return zeros.
- R5: `out_valid` is high exactly in the cycle after an accepted shift command and low otherwise; `out_data` changes only with an accepted shift.
- R6: Each accepted shift adds n to the shift count, saturating at the word width. The register counts as drained when the count is at or above the threshold; a `cfg_thresh` value of 0 stands for the full word width.
- R7: With `cfg_autopull`=1, a shift command that finds the register drained while the queue holds a word is accepted in that cycle, pops the word (`fifo_rd`=1), parcels from the new word and sets the count to n, so one shift completes every clock.
- R8: With `cfg_autopull`=1, a shift command that finds the register drained while the queue is empty sees `cmd_ready`=0, and no pop and no state change happen until a word arrives.
- R9: With `cfg_autopull`=0, shift commands are never stalled and never pop the queue.
- R10: A blocking load (`cmd_block`=1) while the queue is empty holds `cmd_ready` low without popping, and completes in the cycle a word appears.
- R11: A non-blocking load (`cmd_block`=0) while the queue is empty is accepted at once without popping, loads the parameter `FALLBACK_WORD`, and clears the count.
- R12: After reset, `out_valid`, `out_data` and `fifo_rd` are 0, the register holds 0, and the count stands at the full width, so the register starts out drained.
- R13: `fifo_rd` is never high while `fifo_empty` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_left | input | 1 | 1: parcels taken from the MSB end; 0: from the LSB end |
| cfg_autopull | input | 1 | 1: automatic refill on a drained shift |
| cfg_thresh | input | 5 | Drain threshold in bits, 0 meaning 32 |
| cmd_valid | input | 1 | A command is presented |
| cmd_op | input | 1 | 0: shift out, 1: load from queue |
| cmd_cnt | input | 5 | Shift amount, 0 meaning 32 |
| cmd_block | input | 1 | Load waits for data when 1 |
| cmd_ready | output | 1 | Command accepted this cycle when high with `cmd_valid` |
| fifo_empty | input | 1 | Queue has no word |
| fifo_data | input | 32 | Head word of the queue |
| fifo_rd | output | 1 | Pop strobe, one cycle per word |
| out_valid | output | 1 | Parcel on `out_data` is new this cycle |
| out_data | output | 32 | Right-justified output parcel |

## Verification
A corrupted shift count shows first as a refill that comes at the wrong time. A pop appears on `fifo_rd`, or a stall appears on `cmd_ready`, one parcel early or one parcel late. Every parcel after that point then carries bits from the wrong word. An error in the data register or the shifter appears on `out_data` in the cycle after the next accepted shift, as wrong bits or as stray bits above the requested width. Stall and pop errors are visible in the same cycle as the command, with no delay.

// File: rtl/txshift_pkg.sv
// Shared types for the transmit bit-parcel shift register.
// Assumes: nothing beyond a standard SystemVerilog elaborator.
package txshift_pkg;

    // Command opcode carried on cmd_op
    typedef enum logic {
        TXS_OP_SHIFT = 1'b0,
        TXS_OP_LOAD  = 1'b1
    } txs_op_e;

    // Per-cycle decision produced by the command controller
    typedef struct packed {
        logic ready;      // command may complete this cycle
        logic do_shift;   // an output parcel is produced
        logic do_load;    // the register is written with a new word
        logic from_fifo;  // the new word comes from the queue
        logic refill;     // shift operates on the freshly popped word
        logic pop;        // queue read strobe
    } txs_ctrl_t;

endpackage

// File: rtl/txshift_extract.sv
// Combinational parcel extractor.
// Takes AMT bits (1..W) from one end of WORD, returns them right-justified
// in BITS and the zero-filled remainder in REST.
// Assumes: AMT is already decoded into the range 1..W.
module txshift_extract #(
    parameter int W    = 32,
    parameter int CW   = $clog2(W) + 1
) (
    input  logic [W-1:0]  word,
    input  logic [CW-1:0] amt,
    input  logic          left,
    output logic [W-1:0]  bits,
    output logic [W-1:0]  rest
);

    localparam logic [CW-1:0] W_CW = CW'(W);

    logic [2*W-1:0] wide_l;
    logic [2*W-1:0] wide_r;

    // Double-width shifts so a full-width amount needs no special case
    always_comb begin
        wide_l = {{W{1'b0}}, word} << amt;
        wide_r = {word, {W{1'b0}}} >> amt;
    end

    // Select the end the parcel is taken from
    always_comb begin
        if (left) begin
            bits = wide_l[2*W-1:W];
            rest = wide_l[W-1:0];
        end else begin
            bits = wide_r[W-1:0] >> (W_CW - amt);
            rest = wide_r[2*W-1:W];
        end
    end

endmodule

// File: rtl/txshift_count.sv
// Shift counter with saturation and drained flag.
// Counts bits parcelled from the current word; clears on a load and
// saturates at W. Drained when the count reaches the threshold.
// Assumes: AMT and THRESH are decoded into 1..W.
module txshift_count #(
    parameter int W  = 32,
    parameter int CW = $clog2(W) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          advance,
    input  logic [CW-1:0] amt,
    input  logic [CW-1:0] thresh,
    output logic [CW-1:0] level,
    output logic          drained
);

    localparam logic [CW:0] W_EXT = (CW + 1)'(W);

    logic [CW-1:0] base;
    logic [CW:0]   sum;
    logic [CW-1:0] next_level;

    // Next count: start from 0 on a load, add the amount, saturate
    always_comb begin
        base = load ? '0 : level;
        sum  = {1'b0, base} + {1'b0, amt};
        if (advance) begin
            next_level = (sum > W_EXT) ? W_EXT[CW-1:0] : sum[CW-1:0];
        end else if (load) begin
            next_level = '0;
        end else begin
            next_level = level;
        end
    end

    // Count register; resets to full so the first shift sees a drained word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level <= W_EXT[CW-1:0];
        end else begin
            level <= next_level;
        end
    end

    // Drained comparison against the decoded threshold
    always_comb begin
        drained = (level >= thresh);
    end

endmodule

// File: rtl/txshift_ctrl.sv
// Command controller.
// Decides per cycle whether the presented command completes, stalls,
// pops the queue or refills the register.
// Assumes: queue data is valid whenever fifo_empty is low.
module txshift_ctrl
    import txshift_pkg::*;
(
    input  logic      cmd_valid,
    input  txs_op_e   cmd_op,
    input  logic      cmd_block,
    input  logic      autopull,
    input  logic      drained,
    input  logic      fifo_empty,
    output txs_ctrl_t ctl
);

    logic is_shift;
    logic is_load;
    logic want_refill;
    logic shift_stall;
    logic load_stall;

    // Classify the command and find stall conditions
    always_comb begin
        is_shift    = cmd_valid && (cmd_op == TXS_OP_SHIFT);
        is_load     = cmd_valid && (cmd_op == TXS_OP_LOAD);
        want_refill = is_shift && autopull && drained;
        shift_stall = want_refill && fifo_empty;
        load_stall  = is_load && cmd_block && fifo_empty;
    end

    // Build the decision record
    always_comb begin
        ctl.ready     = !(shift_stall || load_stall);
        ctl.do_shift  = is_shift && !shift_stall;
        ctl.refill    = want_refill && !fifo_empty;
        ctl.do_load   = (is_load && !load_stall) || ctl.refill;
        ctl.from_fifo = !fifo_empty;
        ctl.pop       = ctl.refill || (is_load && !fifo_empty);
    end

endmodule

// File: rtl/txshift_unit.sv
// Transmit bit-parcel shift register, top level.
// Holds one word, parcels it out 1..DATA_W bits per command with zero
// fill, refills from the queue on demand or automatically, and stalls
// the requester when no word can be had.
// Assumes: single clock, synchronous active-low reset, queue with
// combinational head data.
module txshift_unit
    import txshift_pkg::*;
#(
    parameter int          DATA_W        = 32,
    parameter logic [31:0] FALLBACK_WORD = 32'h0000_0000,
    localparam int         AW            = $clog2(DATA_W),
    localparam int         CW            = AW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_left,
    input  logic              cfg_autopull,
    input  logic [AW-1:0]     cfg_thresh,
    input  logic              cmd_valid,
    input  logic              cmd_op,
    input  logic [AW-1:0]     cmd_cnt,
    input  logic              cmd_block,
    output logic              cmd_ready,
    input  logic              fifo_empty,
    input  logic [DATA_W-1:0] fifo_data,
    output logic              fifo_rd,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);

    localparam logic [CW-1:0] FULL = CW'(DATA_W);

    txs_ctrl_t        ctl;
    logic [CW-1:0]    amt_dec;
    logic [CW-1:0]    thr_dec;
    logic [CW-1:0]    level;
    logic             drained;
    logic [DATA_W-1:0] sreg;
    logic [DATA_W-1:0] load_word;
    logic [DATA_W-1:0] shift_src;
    logic [DATA_W-1:0] parcel;
    logic [DATA_W-1:0] remainder;

    // Decode zero-means-full encodings of amount and threshold
    always_comb begin
        amt_dec = (cmd_cnt == '0)    ? FULL : {1'b0, cmd_cnt};
        thr_dec = (cfg_thresh == '0) ? FULL : {1'b0, cfg_thresh};
    end

    txshift_ctrl u_ctrl (
        .cmd_valid  (cmd_valid),
        .cmd_op     (txs_op_e'(cmd_op)),
        .cmd_block  (cmd_block),
        .autopull   (cfg_autopull),
        .drained    (drained),
        .fifo_empty (fifo_empty),
        .ctl        (ctl)
    );

    txshift_count #(.W(DATA_W), .CW(CW)) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (ctl.do_load),
        .advance (ctl.do_shift),
        .amt     (amt_dec),
        .thresh  (thr_dec),
        .level   (level),
        .drained (drained)
    );

    // Word offered by a load: queue head, or the fallback when empty
    generate
        if (DATA_W >= 32) begin : g_fb_wide
            assign load_word = ctl.from_fifo ? fifo_data
                                             : DATA_W'(FALLBACK_WORD);
        end else begin : g_fb_narrow
            assign load_word = ctl.from_fifo ? fifo_data
                                             : FALLBACK_WORD[DATA_W-1:0];
        end
    endgenerate

    // Shifter source: freshly popped word during a refill, else the register
    always_comb begin
        shift_src = ctl.refill ? fifo_data : sreg;
    end

    txshift_extract #(.W(DATA_W), .CW(CW)) u_extract (
        .word (shift_src),
        .amt  (amt_dec),
        .left (cfg_left),
        .bits (parcel),
        .rest (remainder)
    );

    // Data register: remainder after a shift, new word after a plain load
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg <= '0;
        end else if (ctl.do_shift) begin
            sreg <= remainder;
        end else if (ctl.do_load) begin
            sreg <= load_word;
        end
    end

    // Output parcel register and its one-cycle valid flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= ctl.do_shift;
            if (ctl.do_shift) begin
                out_data <= parcel;
            end
        end
    end

    // Handshake outputs driven straight from the decision record
    always_comb begin
        cmd_ready = ctl.ready;
        fifo_rd   = ctl.pop;
    end

endmodule

// File: rtl/txshift_unit_chk.sv
// Port-level checker for txshift_unit, attached with bind.
// Assumes: same parameters as the instance it watches.
module txshift_unit_chk #(
    parameter int DATA_W = 32,
    localparam int AW    = $clog2(DATA_W)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_autopull,
    input logic              cmd_valid,
    input logic              cmd_op,
    input logic [AW-1:0]     cmd_cnt,
    input logic              cmd_block,
    input logic              cmd_ready,
    input logic              fifo_empty,
    input logic              fifo_rd,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_data
);

    logic              shift_acc;
    logic [AW-1:0]     last_cnt;
    logic [2*DATA_W-1:0] mask_w;
    logic [DATA_W-1:0] keep_mask;

    assign shift_acc = cmd_valid && cmd_ready && !cmd_op;

    // Remember the amount of the last accepted shift
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_cnt <= '0;
        end else if (shift_acc) begin
            last_cnt <= cmd_cnt;
        end
    end

    // Mask of the bits a parcel of that amount may occupy
    always_comb begin
        mask_w    = {{DATA_W{1'b0}}, {DATA_W{1'b1}}}
                    << ((last_cnt == '0) ? DATA_W : int'(last_cnt));
        keep_mask = mask_w[2*DATA_W-1:DATA_W];
    end

    // R13
    pop_needs_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rd |-> !fifo_empty);

    // R8
    stall_no_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |-> !fifo_rd);

    // R5
    valid_follows_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shift_acc |=> out_valid);

    // R5
    valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_acc |=> !out_valid);

    // R9
    manual_no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_op && !cfg_autopull) |-> (cmd_ready && !fifo_rd));

    // R11
    nb_load_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op && !cmd_block) |-> cmd_ready);

    // R1
    load_pops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op && !fifo_empty) |-> fifo_rd);

    // R2
    parcel_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((out_data & ~keep_mask) == '0));

endmodule

bind txshift_unit txshift_unit_chk #(.DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_autopull (cfg_autopull),
    .cmd_valid    (cmd_valid),
    .cmd_op       (cmd_op),
    .cmd_cnt      (cmd_cnt),
    .cmd_block    (cmd_block),
    .cmd_ready    (cmd_ready),
    .fifo_empty   (fifo_empty),
    .fifo_rd      (fifo_rd),
    .out_valid    (out_valid),
    .out_data     (out_data)
);

// File: tb/sim_txshift_unit.sv
// Directed bench for txshift_unit with a modelled queue.
module sim_txshift_unit;

    localparam int          CLK_PERIOD = 10;
    localparam logic [31:0] FB         = 32'hF0F0_0001;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_left = 1'b0;
    logic        cfg_autopull = 1'b0;
    logic [4:0]  cfg_thresh = 5'd0;
    logic        cmd_valid = 1'b0;
    logic        cmd_op = 1'b0;
    logic [4:0]  cmd_cnt = 5'd0;
    logic        cmd_block = 1'b1;
    logic        cmd_ready;
    logic        fifo_empty;
    logic [31:0] fifo_data;
    logic        fifo_rd;
    logic        out_valid;
    logic [31:0] out_data;

    logic [31:0] fq [64];
    int unsigned wp = 0;
    int unsigned rp = 0;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign fifo_empty = (wp == rp);
    assign fifo_data  = fq[rp % 64];

    always @(posedge clk) if (fifo_rd) rp <= rp + 1;

    txshift_unit #(.DATA_W(32), .FALLBACK_WORD(FB)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_left(cfg_left),
        .cfg_autopull(cfg_autopull), .cfg_thresh(cfg_thresh),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_cnt(cmd_cnt),
        .cmd_block(cmd_block), .cmd_ready(cmd_ready),
        .fifo_empty(fifo_empty), .fifo_data(fifo_data), .fifo_rd(fifo_rd),
        .out_valid(out_valid), .out_data(out_data)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic push(input logic [31:0] w);
        fq[wp % 64] = w;
        wp++;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    // One shift command that must complete in a single cycle
    task automatic do_out(input logic [4:0] n, input logic [31:0] exp,
                          input logic exp_rd, input string req);
        @(negedge clk);
        cmd_valid = 1; cmd_op = 0; cmd_cnt = n; cmd_block = 1;
        #1;
        check({req, " ready"}, 32'(cmd_ready), 32'd1);
        check({req, " pop"}, 32'(fifo_rd), 32'(exp_rd));
        @(posedge clk); #1;
        cmd_valid = 0;
        check({req, " valid"}, 32'(out_valid), 32'd1);
        check({req, " data"}, out_data, exp);
    endtask

    // One load command that must complete in a single cycle
    task automatic do_load(input logic blk, input logic exp_rd, input string req);
        @(negedge clk);
        cmd_valid = 1; cmd_op = 1; cmd_cnt = 0; cmd_block = blk;
        #1;
        check({req, " ready"}, 32'(cmd_ready), 32'd1);
        check({req, " pop"}, 32'(fifo_rd), 32'(exp_rd));
        @(posedge clk); #1;
        cmd_valid = 0;
        check({req, " no parcel"}, 32'(out_valid), 32'd0);
    endtask

    // Present a command that must stall for a number of cycles
    task automatic hold_stall(input logic op, input logic [4:0] n, input logic blk,
                              input int cycles, input string req);
        @(negedge clk);
        cmd_valid = 1; cmd_op = op; cmd_cnt = n; cmd_block = blk;
        for (int i = 0; i < cycles; i++) begin
            #1;
            check({req, " stalled"}, 32'(cmd_ready), 32'd0);
            check({req, " no pop"}, 32'(fifo_rd), 32'd0);
            @(negedge clk);
        end
    endtask

    // Release a held command by pushing a word
    task automatic resume(input logic [31:0] w, input logic [31:0] exp,
                          input logic is_shift, input string req);
        push(w);
        #1;
        check({req, " resumes"}, 32'(cmd_ready), 32'd1);
        check({req, " pops"}, 32'(fifo_rd), 32'd1);
        @(posedge clk); #1;
        cmd_valid = 0;
        check({req, " valid"}, 32'(out_valid), 32'(is_shift));
        if (is_shift) check({req, " data"}, out_data, exp);
    endtask

    task automatic t_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        #1;
        check("R12 out_valid", 32'(out_valid), 32'd0);
        check("R12 out_data", out_data, 32'd0);
        check("R12 fifo_rd", 32'(fifo_rd), 32'd0);
        check("R12 idle ready", 32'(cmd_ready), 32'd1);
    endtask

    task automatic t_right_manual();
        cfg_left = 0; cfg_autopull = 0; cfg_thresh = 0;
        push(32'hA5C3_1E7F);
        do_load(1, 1, "R1 load");
        do_out(5'd8,  32'h0000_007F, 0, "R2 right 8");
        do_out(5'd4,  32'h0000_000E, 0, "R2 right 4");
        do_out(5'd4,  32'h0000_0001, 0, "R2 right 4b");
        do_out(5'd16, 32'h0000_A5C3, 0, "R2 right 16");
        @(posedge clk); #1;
        check("R5 idle valid low", 32'(out_valid), 32'd0);
        check("R5 data held", out_data, 32'h0000_A5C3);
        push(32'h1234_5678);
        do_out(5'd8, 32'h0, 0, "R9 R4 drained manual");
        check("R9 queue untouched", 32'(rp), 32'(wp - 1));
    endtask

    task automatic t_left();
        cfg_left = 1;
        do_load(1, 1, "R1 load left");
        do_out(5'd4, 32'h0000_0001, 0, "R3 left 4");
        do_out(5'd8, 32'h0000_0023, 0, "R3 left 8");
        do_out(5'd0, 32'h4567_8000, 0, "R3 left full");
        do_out(5'd8, 32'h0, 0, "R4 zero fill left");
    endtask

    task automatic t_autopull();
        cfg_left = 0; cfg_autopull = 1; cfg_thresh = 5'd16;
        push(32'hDEAD_BEEF);
        push(32'hCAFE_F00D);
        do_out(5'd8, 32'h0000_00EF, 1, "R7 R12 refill from reset-drained");
        do_out(5'd8, 32'h0000_00BE, 0, "R6 below threshold");
        do_out(5'd8, 32'h0000_000D, 1, "R7 threshold refill");
        do_out(5'd8, 32'h0000_00F0, 0, "R6 continue");
        hold_stall(1'b0, 5'd8, 1'b1, 3, "R8 drained empty");
        resume(32'h1111_22AB, 32'h0000_00AB, 1'b1, "R8 after push");
        cfg_thresh = 5'd0;
        do_out(5'd16, 32'h0000_1122, 0, "R6 thresh 0 means 32");
        push(32'h0000_0055);
        do_out(5'd8, 32'h0000_0011, 0, "R6 count 24 not drained");
        do_out(5'd8, 32'h0000_0055, 1, "R7 refill at 32");
    endtask

    task automatic t_loads();
        cfg_autopull = 0; cfg_left = 0;
        hold_stall(1'b1, 5'd0, 1'b1, 2, "R10 blocking empty");
        cmd_valid = 0;
        do_load(0, 0, "R11 non-blocking empty");
        do_out(5'd0, FB, 0, "R11 fallback word");
        hold_stall(1'b1, 5'd0, 1'b1, 2, "R10 blocking wait");
        resume(32'h600D_F00D, 32'h0, 1'b0, "R10 load completes");
        do_out(5'd0, 32'h600D_F00D, 0, "R10 R1 loaded word");
    endtask

    initial begin
        t_reset();
        t_right_manual();
        t_left();
        t_autopull();
        t_loads();
        repeat (2) @(posedge clk);
        done = 1;
        summary();
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            summary();
            $finish;
        end
    end

endmodule